// File: doc/BRIEF.md
# Bidirectional Parity Transceiver

This block links two eight-bit ports, A and B, and moves a byte between them in one direction at a time. A direction input picks the flow: high moves A onto B (transmit), low moves B onto A (receive). An active-low enable can release every pin the block drives, so the block leaves both ports and the parity pin undriven.

A single parity pin is shared by both modes and changes role with the direction. In transmit the block generates a parity bit over the A byte and drives it out on that pin. In receive the block reads the pin as an input, checks it against the B byte, and flags a mismatch on an active-low error output. A select input chooses the parity sense: high for odd, low for even. The datapath has no registers, so every output follows its inputs in the same evaluation.

Each tri-state pin is modelled as three signals: an input bus (what the outside world drives), an output bus (what the block would drive) and a drive-enable flag. A testbench or a pad ring can then resolve the bus without contention.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: With `oe_n` low and `dir` high (transmit), `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in`. The values of `b_in` have no effect on any output.
- R2: With `oe_n` low and `dir` low (receive), `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in`. The values of `a_in` have no effect on any output.
- R3: With `oe_n` high, `a_oe`, `b_oe` and `par_oe` are all 0 and `err_n` is 1, for every data, direction and parity-sense value.
- R4: In transmit, `par_oe` is 1 and `par_out` makes the number of ones in the nine bits {`a_in`, `par_out`} odd when `odd_sel` is 1 and even when `odd_sel` is 0. For example, even sense with five ones on A gives `par_out` = 1. `par_in` is ignored.
- R5: In receive, `par_oe` is 0, and `err_n` is 0 exactly when the count of ones in {`b_in`, `par_in`} is even with `odd_sel` = 1 or odd with `odd_sel` = 0. For example, odd sense, `par_in` = 1 and three ones on B gives `err_n` = 0.
- R6: In transmit, `err_n` is 1 regardless of data or `par_in`.
- R7: Any output bus whose drive enable is 0 (`a_out`, `b_out`, `par_out`) reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir | input | 1 | Transfer direction: 1 = A to B (transmit), 0 = B to A (receive) |
| oe_n | input | 1 | Active-low enable; high releases all driven pins |
| odd_sel | input | 1 | Parity sense: 1 = odd, 0 = even |
| a_in | input | 8 | Value present on the A pins from outside |
| a_out | output | 8 | Value the block drives onto the A pins |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | 8 | Value present on the B pins from outside |
| b_out | output | 8 | Value the block drives onto the B pins |
| b_oe | output | 1 | Drive enable for the B pins |
| par_in | input | 1 | Value present on the parity pin from outside |
| par_out | output | 1 | Generated parity bit driven onto the parity pin |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low parity error, meaningful in receive only |

## Verification
The hard case to reach is a low `err_n`. It appears only when the block is enabled, in receive mode, and given a parity bit that disagrees with the B byte under the current sense. A correct external sender never produces that combination. The bench therefore drives every byte twice in each mode and sense: once with the parity bit a correct sender would attach, and once with that bit inverted. In transmit mode the same inverted parity bit and a scrambled B byte are applied, which shows that neither one reaches the outputs.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

  typedef enum logic {
    XFER_RX = 1'b0,
    XFER_TX = 1'b1
  } xfer_mode_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic p_en;
    logic chk_en;
  } drive_set_t;

endpackage

// File: rtl/bpx_parity_tree.sv
module bpx_parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  output logic             odd
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int PADW   = 1 << LEVELS;

  // Heap layout: leaves at PADW..2*PADW-1, root at index 1.
  logic [2*PADW-1:1] node;

  genvar gl;
  generate
    for (gl = 0; gl < PADW; gl++) begin : g_leaf
      if (gl < WIDTH) begin : g_used
        assign node[PADW+gl] = data[gl];
      end else begin : g_pad
        assign node[PADW+gl] = 1'b0;
      end
    end
  endgenerate

  genvar gn;
  generate
    for (gn = 1; gn < PADW; gn++) begin : g_node
      assign node[gn] = node[2*gn] ^ node[2*gn+1];
    end
  endgenerate

  assign odd = node[1];
endmodule

// File: rtl/bpx_dir_ctrl.sv
module bpx_dir_ctrl
  import bpx_pkg::*;
(
  input  logic       dir,
  input  logic       oe_n,
  output xfer_mode_e mode,
  output drive_set_t drv
);
  always_comb begin
    mode       = dir ? XFER_TX : XFER_RX;
    drv.a_en   = 1'b0;
    drv.b_en   = 1'b0;
    drv.p_en   = 1'b0;
    drv.chk_en = 1'b0;
    if (!oe_n) begin
      unique case (mode)
        XFER_TX: begin
          drv.b_en = 1'b1;
          drv.p_en = 1'b1;
        end
        XFER_RX: begin
          drv.a_en   = 1'b1;
          drv.chk_en = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bpx_parity_unit.sv
module bpx_parity_unit
  import bpx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  xfer_mode_e       mode,
  input  logic             odd_sel,
  input  logic [WIDTH-1:0] a_data,
  input  logic [WIDTH-1:0] b_data,
  input  logic             par_rx,
  output logic             par_gen,
  output logic             par_ok
);
  logic [WIDTH-1:0] tree_in;
  logic             tree_odd;
  logic             sensed;

  // One reduction tree serves both directions: only one byte matters at a time.
  assign tree_in = (mode == XFER_TX) ? a_data : b_data;

  bpx_parity_tree #(.WIDTH(WIDTH)) u_tree (
    .data (tree_in),
    .odd  (tree_odd)
  );

  // sensed = bit that completes the selected sense over tree_in.
  assign sensed  = tree_odd ^ odd_sel;
  assign par_gen = sensed;
  assign par_ok  = ~(sensed ^ par_rx);
endmodule

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr
  import bpx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir,
  input  logic             oe_n,
  input  logic             odd_sel,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_n
);
  xfer_mode_e mode;
  drive_set_t drv;
  logic       par_gen;
  logic       par_ok;

  bpx_dir_ctrl u_ctrl (
    .dir  (dir),
    .oe_n (oe_n),
    .mode (mode),
    .drv  (drv)
  );

  bpx_parity_unit #(.WIDTH(WIDTH)) u_par (
    .mode    (mode),
    .odd_sel (odd_sel),
    .a_data  (a_in),
    .b_data  (b_in),
    .par_rx  (par_in),
    .par_gen (par_gen),
    .par_ok  (par_ok)
  );

  always_comb begin
    a_out   = drv.a_en ? b_in : '0;
    b_out   = drv.b_en ? a_in : '0;
    par_out = drv.p_en & par_gen;
    err_n   = drv.chk_en ? par_ok : 1'b1;
  end

  assign a_oe   = drv.a_en;
  assign b_oe   = drv.b_en;
  assign par_oe = drv.p_en;
endmodule

// File: rtl/bidir_parity_xcvr_chk.sv
module bidir_parity_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             dir,
  input logic             oe_n,
  input logic             odd_sel,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             par_in,
  input logic             par_out,
  input logic             par_oe,
  input logic             err_n
);
  always_comb begin
    if (oe_n) begin
      assert_release_R3: assert (!a_oe && !b_oe && !par_oe && err_n);
    end
    if (!oe_n && dir) begin
      assert_tx_path_R1: assert (b_oe && !a_oe && (b_out == a_in));
      assert_tx_parity_R4: assert (par_oe && (($countones({a_in, par_out}) % 2) == int'(odd_sel)));
      assert_tx_noerr_R6: assert (err_n);
    end
    if (!oe_n && !dir) begin
      assert_rx_path_R2: assert (a_oe && !b_oe && (a_out == b_in));
      assert_rx_check_R5: assert (!par_oe &&
        (err_n == (($countones({b_in, par_in}) % 2) == int'(odd_sel))));
    end
    assert_idle_zero_R7: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0) &&
                                 (par_oe || !par_out));
  end
endmodule

bind bidir_parity_xcvr bidir_parity_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_bidir_parity_xcvr.sv
module test_bidir_parity_xcvr;
  logic       clk = 1'b0;
  logic       dir, oe_n, odd_sel, par_in;
  logic [7:0] a_in, b_in;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe, par_out, par_oe, err_n;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  bidir_parity_xcvr i_bidir_parity_xcvr (
    .dir     (dir),
    .oe_n    (oe_n),
    .odd_sel (odd_sel),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .par_in  (par_in),
    .par_out (par_out),
    .par_oe  (par_oe),
    .err_n   (err_n)
  );

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (dir=%0d oe_n=%0d odd=%0d a=%02h b=%02h p=%0d)",
               req, act, exp, dir, oe_n, odd_sel, a_in, b_in, par_in);
    end
  endtask

  task automatic run_all();
    // Disabled state at start.
    dir = 1'b1; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0; a_in = '0; b_in = '0;
    @(negedge clk);
    chk("R3 start a_oe", int'(a_oe), 0);
    chk("R3 start b_oe", int'(b_oe), 0);
    chk("R3 start par_oe", int'(par_oe), 0);
    chk("R3 start err_n", int'(err_n), 1);

    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 256; v++) begin
          for (int f = 0; f < 2; f++) begin
            int par_good;
            @(posedge clk);
            dir = d[0]; oe_n = 1'b0; odd_sel = s[0];
            if (d == 1) begin
              a_in = v[7:0]; b_in = ~v[7:0] ^ 8'h5a;
              par_good = ((ones(v[7:0]) % 2) != s) ? 1 : 0;
            end else begin
              b_in = v[7:0]; a_in = v[7:0] ^ 8'hc3;
              par_good = ((ones(v[7:0]) % 2) != s) ? 1 : 0;
            end
            par_in = (f == 1) ? ~par_good[0] : par_good[0];
            @(negedge clk);
            if (d == 1) begin
              chk("R1 b_oe", int'(b_oe), 1);
              chk("R1 a_oe", int'(a_oe), 0);
              chk("R1 b_out", int'(b_out), v);
              chk("R4 par_oe", int'(par_oe), 1);
              chk("R4 par_out", int'(par_out), par_good);
              chk("R6 err_n", int'(err_n), 1);
              chk("R7 a_out", int'(a_out), 0);
            end else begin
              chk("R2 a_oe", int'(a_oe), 1);
              chk("R2 b_oe", int'(b_oe), 0);
              chk("R2 a_out", int'(a_out), v);
              chk("R5 par_oe", int'(par_oe), 0);
              chk("R5 err_n", int'(err_n), (f == 1) ? 0 : 1);
              chk("R7 b_out", int'(b_out), 0);
              chk("R7 par_out", int'(par_out), 0);
            end
          end
        end
      end
    end

    // Disabled sweep across modes and senses.
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 256; v += 17) begin
          @(posedge clk);
          dir = d[0]; oe_n = 1'b1; odd_sel = s[0];
          a_in = v[7:0]; b_in = ~v[7:0]; par_in = v[0];
          @(negedge clk);
          chk("R3 a_oe", int'(a_oe), 0);
          chk("R3 b_oe", int'(b_oe), 0);
          chk("R3 par_oe", int'(par_oe), 0);
          chk("R3 err_n", int'(err_n), 1);
          chk("R7 idle a_out", int'(a_out), 0);
          chk("R7 idle b_out", int'(b_out), 0);
          chk("R7 idle par_out", int'(par_out), 0);
        end
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R1..R7 run) actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule